// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block looks at every address a bus master puts out and turns it into active-low select lines for the memory and peripheral devices hanging off that bus. Three memory regions are decoded: one pinned to the top of the 1 MB space, one pinned to address zero, and one relocatable mid-range region that is split evenly across four selects. A fourth region is a run of seven contiguous 128-byte peripheral blocks above a 1K-aligned base, which can sit in memory space or in the 16-bit I/O space. Each region carries its own wait-state count, which the block reports for whichever region is selected in the current cycle.

Software loads the control words through a plain register-write port. A cycle is decoded while the address strobe is high, and the outputs follow the address and qualifier without any register in between. The two topmost peripheral selects can be given a different job. They then carry address bits A1 and A2, captured on each strobed clock edge. This lets a device that needs those bits after the address phase receive them.

Top module: `chipsel_unit`

## Requirements
- R1: While `strobe` is low, every select line is high; a pin that is in address mode (R10) still shows its captured bit.
- R2: The top region covers the last `1K << code` bytes, so it ends at FFFFFh. Its control word (register 0) holds enable in bit 15, the size code in bits 7:4 and the wait count in bits 1:0. Out of reset only this region is enabled, with code 8 (256K) and wait count 3.
- R3: The bottom region (register 1, same layout as R2) covers addresses 0 up to `1K << code` - 1.
- R4: Size codes 0 to 8 select 1K to 256K. A region whose code is 9 to 15 never matches.
- R5: The mid region takes its control word from register 2 (layout of R2) and its base from register 3, where bits 15:6 give address bits 19:10. Base bits below the region size are ignored. The region is split into four equal quarters, and quarter i drives `mcs_n[i]`.
- R6: At most one select is active at a time. The priority is top region, then bottom region, then mid region, then the peripheral blocks.
- R7: `wait_cnt` equals the wait field of the region whose select is active, and is 0 when no select is active.
- R8: The peripheral area has its base in register 4 (bits 15:6 give address bits 19:10) and its control in register 5. In register 5, bit 15 is enable, bit 3 is address mode, bit 2 selects I/O space and bits 1:0 hold the wait count. Block i (base + 128*i, for i from 0 to 6) drives `pcs_n[i]`. Offsets 896 to 1023 from the base select nothing.
- R9: With bit 2 set, the peripheral area matches only I/O cycles (`is_mem`=0). Only address bits 15:10 are compared, against base bits 11:6. Base bits 15:12 and address bits 19:16 are ignored. With bit 2 clear, it matches only memory cycles.
- R10: With address mode set, `pcs_n[5]` and `pcs_n[6]` output address bits A1 and A2, captured at the last clock edge where `strobe` was high (0 after reset). Blocks 5 and 6 are then never selected.
- R11: The top, bottom and mid selects assert only on memory cycles (`is_mem`=1).
- R12: A write with `wr_sel` of 6 or 7 changes no decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index for the write |
| wr_data | input | 16 | Write data |
| addr | input | 20 | Bus address |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| strobe | input | 1 | Address valid qualifier |
| ucs_n | output | 1 | Top region select, active low |
| lcs_n | output | 1 | Bottom region select, active low |
| mcs_n | output | 4 | Mid region quarter selects, active low |
| pcs_n | output | 7 | Peripheral block selects, active low; bits 5 and 6 may carry A1 and A2 |
| wait_cnt | output | 2 | Wait-state count of the selected region |

## Verification
The main overlap is a single address that lands in two windows at once. This happens when the mid region or the peripheral area is placed inside the top or bottom region. Only the higher-priority select may fire in that case, and `wait_cnt` must come from that same region. The sweeps set up such overlaps on purpose and compare every line with an arithmetic model of the priority chain. The second overlap is in time: in address mode, one strobed cycle both decodes a peripheral block and captures A1/A2. The bench tracks the captured bits of the previous strobed address, and the checks confirm that pins 5 and 6 show those bits rather than a select.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;

    localparam int CS_ADDR_W  = 20;                     // bus address width
    localparam int CS_DATA_W  = 16;                     // register write width
    localparam int CS_IO_W    = 16;                     // I/O address width
    localparam int CS_GRAN_W  = 10;                     // 1K granule
    localparam int CS_BLK_W   = 7;                      // 128-byte peripheral block
    localparam int CS_NSIZE   = 9;                      // legal size codes 0..8
    localparam int CS_CODE_W  = 4;
    localparam int CS_WS_W    = 2;
    localparam int CS_SEL_W   = 3;
    localparam int CS_N_MID   = 4;
    localparam int CS_N_PER   = 7;
    localparam int CS_N_ALT   = 2;                      // top selects usable as address outputs
    localparam int CS_BASE_W  = CS_ADDR_W - CS_GRAN_W;
    localparam int CS_BIDX_W  = CS_GRAN_W - CS_BLK_W;

    // control word field positions
    localparam int CS_F_EN      = 15;
    localparam int CS_F_CODE_LO = 4;
    localparam int CS_F_AMODE   = 3;
    localparam int CS_F_IO      = 2;

    localparam logic [CS_SEL_W-1:0] CS_REG_UP   = CS_SEL_W'(0);
    localparam logic [CS_SEL_W-1:0] CS_REG_LO   = CS_SEL_W'(1);
    localparam logic [CS_SEL_W-1:0] CS_REG_MID  = CS_SEL_W'(2);
    localparam logic [CS_SEL_W-1:0] CS_REG_MIDB = CS_SEL_W'(3);
    localparam logic [CS_SEL_W-1:0] CS_REG_PERB = CS_SEL_W'(4);
    localparam logic [CS_SEL_W-1:0] CS_REG_PER  = CS_SEL_W'(5);

    typedef struct packed {
        logic                 en;
        logic [CS_CODE_W-1:0] code;
        logic [CS_WS_W-1:0]   ws;
    } win_cfg_t;

    typedef struct packed {
        logic                 en;
        logic                 io;
        logic                 amode;
        logic [CS_WS_W-1:0]   ws;
        logic [CS_BASE_W-1:0] base;
    } per_cfg_t;

    typedef struct packed {
        win_cfg_t             up;
        win_cfg_t             lo;
        win_cfg_t             mid;
        logic [CS_BASE_W-1:0] mid_base;
        per_cfg_t             per;
    } cs_cfg_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_UP, RG_LO, RG_MID, RG_PER
    } region_e;

    function automatic logic size_ok(input logic [CS_CODE_W-1:0] code);
        return int'(code) < CS_NSIZE;
    endfunction

    // address bits that must equal the anchor for a window of this size
    function automatic logic [CS_ADDR_W-1:0] hi_mask(input logic [CS_CODE_W-1:0] code);
        return {CS_ADDR_W{1'b1}} << (CS_GRAN_W + int'(code));
    endfunction

    function automatic win_cfg_t word_to_win(input logic [CS_DATA_W-1:0] d);
        win_cfg_t w;
        w.en   = d[CS_F_EN];
        w.code = d[CS_F_CODE_LO +: CS_CODE_W];
        w.ws   = d[CS_WS_W-1:0];
        return w;
    endfunction

    function automatic logic [CS_BASE_W-1:0] word_to_base(input logic [CS_DATA_W-1:0] d);
        return d[CS_DATA_W-1 -: CS_BASE_W];
    endfunction

endpackage

// File: rtl/chipsel_regs.sv
module chipsel_regs
    import chipsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CS_SEL_W-1:0]  wr_sel,
    input  logic [CS_DATA_W-1:0] wr_data,
    output cs_cfg_t              cfg
);

    localparam logic [CS_CODE_W-1:0] RST_CODE = CS_CODE_W'(CS_NSIZE - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg          <= '0;
            cfg.up.en    <= 1'b1;
            cfg.up.code  <= RST_CODE;
            cfg.up.ws    <= '1;
        end else if (wr_en) begin
            case (wr_sel)
                CS_REG_UP:   cfg.up       <= word_to_win(wr_data);
                CS_REG_LO:   cfg.lo       <= word_to_win(wr_data);
                CS_REG_MID:  cfg.mid      <= word_to_win(wr_data);
                CS_REG_MIDB: cfg.mid_base <= word_to_base(wr_data);
                CS_REG_PERB: cfg.per.base <= word_to_base(wr_data);
                CS_REG_PER: begin
                    cfg.per.en    <= wr_data[CS_F_EN];
                    cfg.per.io    <= wr_data[CS_F_IO];
                    cfg.per.amode <= wr_data[CS_F_AMODE];
                    cfg.per.ws    <= wr_data[CS_WS_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/chipsel_win.sv
module chipsel_win
    import chipsel_pkg::*;
#(
    parameter int N_SUB = 1
) (
    input  logic [CS_ADDR_W-1:0] addr,
    input  win_cfg_t             wc,
    input  logic [CS_BASE_W-1:0] anchor,
    output logic                 hit,
    output logic [N_SUB-1:0]     sub_hit
);

    logic [CS_ADDR_W-1:0] mask;
    logic [CS_ADDR_W-1:0] anchor_addr;

    always_comb begin
        mask        = hi_mask(wc.code);
        anchor_addr = {anchor, {CS_GRAN_W{1'b0}}};
        hit         = wc.en && size_ok(wc.code) && (((addr ^ anchor_addr) & mask) == '0);
    end

    if (N_SUB > 1) begin : g_split
        localparam int SUB_W = $clog2(N_SUB);
        logic [SUB_W-1:0] idx;
        always_comb begin
            idx     = SUB_W'(addr >> (CS_GRAN_W + int'(wc.code) - SUB_W));
            sub_hit = hit ? (N_SUB'(1) << idx) : '0;
        end
    end else begin : g_whole
        assign sub_hit = hit;
    end

endmodule

// File: rtl/chipsel_per.sv
module chipsel_per
    import chipsel_pkg::*;
(
    input  logic [CS_ADDR_W-1:0] addr,
    input  logic                 is_mem,
    input  per_cfg_t             pc,
    output logic                 hit,
    output logic [CS_N_PER-1:0]  blk_hit
);

    localparam int IO_HI = CS_IO_W - CS_GRAN_W;

    logic                 mem_match;
    logic                 io_match;
    logic                 area_match;
    logic [CS_BIDX_W-1:0] blk;

    always_comb begin
        mem_match  = is_mem && (addr[CS_ADDR_W-1:CS_GRAN_W] == pc.base);
        io_match   = !is_mem && (addr[CS_IO_W-1:CS_GRAN_W] == pc.base[IO_HI-1:0]);
        area_match = pc.en && (pc.io ? io_match : mem_match);
        blk        = addr[CS_GRAN_W-1:CS_BLK_W];
    end

    for (genvar i = 0; i < CS_N_PER; i++) begin : g_blk
        if (i >= CS_N_PER - CS_N_ALT) begin : g_alt
            assign blk_hit[i] = area_match && !pc.amode && (int'(blk) == i);
        end else begin : g_fix
            assign blk_hit[i] = area_match && (int'(blk) == i);
        end
    end

    assign hit = |blk_hit;

endmodule

// File: rtl/chipsel_unit.sv
module chipsel_unit
    import chipsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [15:0]          wr_data,
    input  logic [19:0]          addr,
    input  logic                 is_mem,
    input  logic                 strobe,
    output logic                 ucs_n,
    output logic                 lcs_n,
    output logic [3:0]           mcs_n,
    output logic [6:0]           pcs_n,
    output logic [1:0]           wait_cnt
);

    cs_cfg_t               cfg;
    logic                  up_hit, lo_hit, mid_hit, per_hit;
    logic                  up_sub, lo_sub;
    logic [CS_N_MID-1:0]   mid_sub;
    logic [CS_N_PER-1:0]   per_blk;
    logic [CS_N_PER-1:0]   per_act;
    logic [CS_N_ALT-1:0]   lat_q;
    logic                  per_amode;
    region_e               rg;

    chipsel_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    chipsel_win #(.N_SUB(1)) u_up (
        .addr    (addr),
        .wc      (cfg.up),
        .anchor  ({CS_BASE_W{1'b1}}),
        .hit     (up_hit),
        .sub_hit (up_sub)
    );

    chipsel_win #(.N_SUB(1)) u_lo (
        .addr    (addr),
        .wc      (cfg.lo),
        .anchor  ({CS_BASE_W{1'b0}}),
        .hit     (lo_hit),
        .sub_hit (lo_sub)
    );

    chipsel_win #(.N_SUB(CS_N_MID)) u_mid (
        .addr    (addr),
        .wc      (cfg.mid),
        .anchor  (cfg.mid_base),
        .hit     (mid_hit),
        .sub_hit (mid_sub)
    );

    chipsel_per u_per (
        .addr    (addr),
        .is_mem  (is_mem),
        .pc      (cfg.per),
        .hit     (per_hit),
        .blk_hit (per_blk)
    );

    // fixed priority: top, bottom, mid, peripheral
    always_comb begin
        rg = RG_NONE;
        if (strobe) begin
            if (is_mem && up_sub)       rg = RG_UP;
            else if (is_mem && lo_sub)  rg = RG_LO;
            else if (is_mem && mid_hit) rg = RG_MID;
            else if (per_hit)           rg = RG_PER;
        end
    end

    always_comb begin
        ucs_n   = !(rg == RG_UP);
        lcs_n   = !(rg == RG_LO);
        mcs_n   = ~((rg == RG_MID) ? mid_sub : '0);
        per_act = (rg == RG_PER) ? per_blk : '0;
        case (rg)
            RG_UP:   wait_cnt = cfg.up.ws;
            RG_LO:   wait_cnt = cfg.lo.ws;
            RG_MID:  wait_cnt = cfg.mid.ws;
            RG_PER:  wait_cnt = cfg.per.ws;
            default: wait_cnt = '0;
        endcase
    end

    // captured A1.. address bits for the alternate pin function
    always_ff @(posedge clk) begin
        if (rst)         lat_q <= '0;
        else if (strobe) lat_q <= addr[CS_N_ALT:1];
    end

    assign per_amode = cfg.per.amode;

    for (genvar i = 0; i < CS_N_PER; i++) begin : g_pcs
        if (i >= CS_N_PER - CS_N_ALT) begin : g_alt
            assign pcs_n[i] = per_amode ? lat_q[i - (CS_N_PER - CS_N_ALT)] : ~per_act[i];
        end else begin : g_fix
            assign pcs_n[i] = ~per_act[i];
        end
    end

endmodule

// File: rtl/chipsel_unit_chk.sv
module chipsel_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       strobe,
    input logic       is_mem,
    input logic [1:0] addr_hi,
    input logic [1:0] addr_lat,
    input logic       ucs_n,
    input logic       lcs_n,
    input logic [3:0] mcs_n,
    input logic [6:0] pcs_n,
    input logic [1:0] wait_cnt,
    input logic       amode
);

    logic       seen;
    logic [1:0] alt_act;
    logic       any_sel;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    always_comb begin
        alt_act = amode ? 2'b00 : ~pcs_n[6:5];
        any_sel = !ucs_n || !lcs_n || !(&mcs_n) || !(&pcs_n[4:0]) || (|alt_act);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> !any_sel); // R1

    AST_TOP_REGION: assert property (@(posedge clk) disable iff (rst)
        !ucs_n |-> (&addr_hi)); // R2

    AST_BOTTOM_REGION: assert property (@(posedge clk) disable iff (rst)
        !lcs_n |-> (addr_hi == 2'b00)); // R3

    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones({~ucs_n, ~lcs_n, ~mcs_n, ~pcs_n[4:0], alt_act}) <= 1); // R6

    AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !any_sel |-> (wait_cnt == 2'b00)); // R7

    AST_ALT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (seen && amode && $past(strobe)) |-> (pcs_n[6:5] == $past(addr_lat))); // R10

    AST_MEM_ONLY: assert property (@(posedge clk) disable iff (rst)
        !is_mem |-> (ucs_n && lcs_n && (&mcs_n))); // R11

endmodule

bind chipsel_unit chipsel_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .is_mem   (is_mem),
    .addr_hi  (addr[19:18]),
    .addr_lat (addr[2:1]),
    .ucs_n    (ucs_n),
    .lcs_n    (lcs_n),
    .mcs_n    (mcs_n),
    .pcs_n    (pcs_n),
    .wait_cnt (wait_cnt),
    .amode    (per_amode)
);

// File: tb/chipsel_unit_test.sv
module chipsel_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [19:0] addr = '0;
    logic        is_mem = 1'b1;
    logic        strobe = 1'b0;
    logic        ucs_n, lcs_n;
    logic [3:0]  mcs_n;
    logic [6:0]  pcs_n;
    logic [1:0]  wait_cnt;

    int total = 0;
    int bad   = 0;

    // shadow configuration
    int u_en, u_code, u_ws;
    int l_en, l_code, l_ws;
    int m_en, m_code, m_ws, m_base;
    int p_en, p_io, p_am, p_ws, p_base;
    logic [1:0] lat;

    chipsel_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr(addr), .is_mem(is_mem), .strobe(strobe),
        .ucs_n(ucs_n), .lcs_n(lcs_n), .mcs_n(mcs_n), .pcs_n(pcs_n), .wait_cnt(wait_cnt)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic model(input int a, input bit mem, input bit stb,
                         output logic [12:0] v_n, output int ws);
        logic [12:0] act;
        int sz, mb, pb, pa, blk;
        act = '0;
        ws  = 0;
        if (stb) begin
            if (mem && u_en != 0 && u_code <= 8 && a >= 1048576 - (1024 << u_code)) begin
                act[12] = 1'b1; ws = u_ws;
            end else if (mem && l_en != 0 && l_code <= 8 && a < (1024 << l_code)) begin
                act[11] = 1'b1; ws = l_ws;
            end else begin
                sz = 1024 << m_code;
                mb = (m_base / sz) * sz;
                if (mem && m_en != 0 && m_code <= 8 && a >= mb && a < mb + sz) begin
                    act[7 + (a - mb) / (sz / 4)] = 1'b1; ws = m_ws;
                end else begin
                    pb = (p_io != 0) ? ((p_base >> 10) & 63) * 1024 : p_base;
                    pa = (p_io != 0) ? (a & 65535) : a;
                    if (p_en != 0 && ((p_io != 0) ? !mem : mem) && pa >= pb && pa < pb + 896) begin
                        blk = (pa - pb) / 128;
                        if (!(p_am != 0 && blk >= 5)) begin
                            act[blk] = 1'b1; ws = p_ws;
                        end
                    end
                end
            end
        end
        v_n = ~act;
        if (p_am != 0) v_n[6:5] = lat;
    endtask

    task automatic check_at(input int a, input bit mem, input bit stb, input string tag);
        logic [12:0] exp_n, got_n;
        int exp_ws;
        @(negedge clk);
        addr   = a[19:0];
        is_mem = mem;
        strobe = stb;
        #1;
        model(a, mem, stb, exp_n, exp_ws);
        got_n = {ucs_n, lcs_n, mcs_n, pcs_n};
        total++;
        if (got_n !== exp_n || int'(wait_cnt) != exp_ws) begin
            bad++;
            $display("FAIL %s addr=%05h mem=%0d stb=%0d: actual sel=%013b ws=%0d expected sel=%013b ws=%0d",
                     tag, a, mem, stb, got_n, wait_cnt, exp_n, exp_ws);
        end
        @(posedge clk);
        if (stb) lat = a[2:1];
    endtask

    task automatic sweep(input int lo, input int hi, input int step, input bit mem,
                         input bit stb, input string tag);
        for (int x = lo; x <= hi; x += step)
            if (x >= 0 && x < 1048576) check_at(x, mem, stb, tag);
    endtask

    task automatic edges(input int b, input string tag);
        sweep(b - 3, b + 3, 1, 1'b1, 1'b1, tag);
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        strobe  = 1'b0;
        wr_en   = 1'b1;
        wr_sel  = sel[2:0];
        wr_data = data[15:0];
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic set_win(input int sel, input int en, input int code, input int ws);
        wr(sel, (en << 15) | (code << 4) | ws);
        case (sel)
            0: begin u_en = en; u_code = code; u_ws = ws; end
            1: begin l_en = en; l_code = code; l_ws = ws; end
            default: begin m_en = en; m_code = code; m_ws = ws; end
        endcase
    endtask

    task automatic set_mid_base(input int a);
        wr(3, (a >> 10) << 6);
        m_base = a;
    endtask

    task automatic set_per(input int en, input int io, input int am, input int ws, input int base);
        wr(4, (base >> 10) << 6);
        wr(5, (en << 15) | (am << 3) | (io << 2) | ws);
        p_en = en; p_io = io; p_am = am; p_ws = ws; p_base = base;
    endtask

    initial begin
        u_en = 1; u_code = 8; u_ws = 3;
        l_en = 0; l_code = 0; l_ws = 0;
        m_en = 0; m_code = 0; m_ws = 0; m_base = 0;
        p_en = 0; p_io = 0; p_am = 0; p_ws = 0; p_base = 0;
        lat = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state: top 256K window with 3 wait states
        check_at(32'hFFFF0, 1'b1, 1'b1, "R2 reset fetch");
        edges(32'hC0000, "R2 reset lower bound");
        sweep(0, 1048575, 4093, 1'b1, 1'b1, "R2 reset sweep");

        // R1: strobe low silences everything
        sweep(0, 1048575, 65521, 1'b1, 1'b0, "R1 strobe low");

        // configuration A: disjoint regions, unaligned mid base (R5)
        set_win(0, 1, 2, 1);
        set_win(1, 1, 4, 2);
        set_win(2, 1, 6, 0);
        set_mid_base(32'h41000);
        set_per(1, 0, 0, 3, 32'h20000);
        sweep(0, 1048575, 1021, 1'b1, 1'b1, "R2 R3 R5 sweep A");
        sweep(0, 1048575, 8191, 1'b0, 1'b1, "R11 io sweep A");
        edges(32'hFF000, "R2 top bound");
        edges(32'h04000, "R3 bottom bound");
        for (int q = 0; q <= 4; q++) edges(32'h40000 + q * 16384, "R5 quarter bound");
        sweep(32'h1FF80, 32'h20480, 16, 1'b1, 1'b1, "R8 periph mem blocks");
        sweep(32'h20000, 32'h20400, 16, 1'b0, 1'b1, "R9 periph not on io");
        sweep(32'h20000, 32'h20400, 64, 1'b1, 1'b0, "R1 periph strobe low");

        // configuration B: overlaps and I/O peripheral with address mode (R6 R10 R9)
        set_win(0, 1, 8, 0);
        set_win(1, 1, 8, 1);
        set_win(2, 1, 3, 2);
        set_mid_base(32'h00000);
        set_per(1, 1, 1, 2, 32'hA0C00);
        sweep(0, 1048575, 1021, 1'b1, 1'b1, "R6 overlap sweep B");
        sweep(32'h00000, 32'h02400, 32, 1'b1, 1'b1, "R6 mid under bottom");
        sweep(32'h00B80, 32'h01080, 8, 1'b0, 1'b1, "R9 R10 io blocks");
        sweep(32'h50B80, 32'h51080, 8, 1'b0, 1'b1, "R9 io high bits ignored");
        sweep(32'h00C00, 32'h00FFF, 1, 1'b0, 1'b1, "R10 captured A1 A2");
        set_win(0, 0, 8, 0);
        set_win(1, 0, 8, 0);
        set_mid_base(32'hC4000);
        set_win(2, 1, 5, 2);
        sweep(32'hC0000, 32'hD0000, 512, 1'b1, 1'b1, "R5 mid alone B");
        set_win(0, 1, 8, 3);
        sweep(32'hC0000, 32'hD0000, 512, 1'b1, 1'b1, "R6 top over mid");

        // configuration C: illegal size codes, peripheral tail (R4 R8)
        set_win(0, 1, 9, 1);
        set_win(1, 1, 15, 2);
        set_win(2, 1, 12, 3);
        set_per(1, 0, 0, 1, 32'h7FC00);
        sweep(0, 1048575, 2039, 1'b1, 1'b1, "R4 illegal codes");
        sweep(32'h7FB00, 32'h80100, 8, 1'b1, 1'b1, "R8 block tail");

        // configuration D: smallest mid window, 256-byte quarters (R4 R5 R7)
        set_win(0, 0, 0, 0);
        set_win(1, 0, 0, 0);
        set_win(2, 1, 0, 3);
        set_mid_base(32'h12C00);
        sweep(32'h12B00, 32'h13100, 4, 1'b1, 1'b1, "R4 R5 R7 1K mid");

        // R12: writes to unused indices leave decoding unchanged
        wr(6, 16'hFFFF);
        wr(7, 16'hFFFF);
        sweep(32'h12B00, 32'h13100, 32, 1'b1, 1'b1, "R12 unused index");
        sweep(32'h7FB00, 32'h80100, 32, 1'b1, 1'b1, "R12 unused index per");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule